// File: doc/BRIEF.md
# Half-Duplex Programming-Port Link PHY

This block is the target-side physical layer of a three-wire programming port. A host drives a bit clock, an active-high link enable, and shares one bidirectional data wire with the target. The PHY runs entirely on the host bit clock and samples the wire once per clock. It either receives or transmits, never both at once. Received frames become bytes on a valid/ready stream towards the access layer above it. Bytes offered on a second valid/ready stream are framed and driven onto the wire.

Each frame is 12 bit periods long and its bits have a fixed order. A low start bit comes first, then 8 data bits with the least significant bit first. An even-parity bit follows, and the frame ends with two high stop bits. The idle level of the wire is high. The receiver flags parity errors, frame errors and break conditions on single-cycle strobes. The transmitter computes parity itself. Before it drives any response to a reception, it waits a guard interval of idle bit periods. While it drives, it compares each bit it sends with the level it samples back from the wire.

The pin is split into a sampled input `dat_i`, a driven value `dat_o` and an output enable `dat_oe`. The tri-state buffer sits outside the block. Receive back-pressure: `rx_valid` and `rx_data` hold until a cycle with `rx_ready` high. The host clock cannot be stalled, so a newer good frame replaces a byte that has not been taken. Transmit back-pressure: a byte is taken at the rising edge where `tx_valid` and `tx_ready` are both high, and `tx_data` must be stable while `tx_valid` waits.

Top module: `prog_phy`

## Requirements
- R1: A frame that starts with a low bit, carries data bits LSB first, has a parity bit equal to the XOR of the 8 data bits and has both stop bits high is delivered. `rx_data` shows its byte and `rx_valid` is high in the cycle after the second stop bit is sampled.
- R2: `rx_valid` and `rx_data` hold while `rx_ready` is low. `rx_valid` clears after a rising edge with `rx_ready` high. A newer good frame overwrites a byte that has not been taken.
- R3: A frame whose parity bit differs from the XOR of its data bits pulses `perr` for one cycle, in the cycle after its last stop bit, and delivers no byte.
- R4: A frame with either stop bit low pulses `ferr` for one cycle, in the cycle after its last stop bit, and delivers no byte.
- R5: The 12th consecutive low sample pulses `brk` for one cycle. It aborts any frame being received, with no `perr`, `ferr` or byte. The line must then go high before a new frame can start.
- R6: A frame starts only at a high-to-low transition of the sampled line while the block is not transmitting.
- R7: `tx_ready` stays low after enable, after a received frame and after a break until the line has been sampled high in GUARD_BITS consecutive idle cycles.
- R8: A byte taken by a handshake is sent in the 12 cycles after that edge. The order is a low start bit, data LSB first, even parity, then two high stops. `dat_oe` is high for exactly those 12 cycles.
- R9: During the last stop bit of a frame being sent, `tx_ready` is high, so a following byte goes out with no idle gap.
- R10: While driving, a sampled `dat_i` that differs from `dat_o` pulses `col` in the next cycle. A host pulling low during a low bit causes no pulse.
- R11: The block never treats its own transmitted frame as received data.
- R12: With `link_en` low, all state is cleared at once. `dat_oe`, `rx_valid`, `tx_ready` and all strobes are low, and `dat_o` rests high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bit clock; the line is sampled on its rising edge |
| link_en | input | 1 | Active-high link enable; low holds the block in reset |
| dat_i | input | 1 | Sampled level of the shared data wire |
| dat_o | output | 1 | Value driven onto the wire when enabled |
| dat_oe | output | 1 | Output enable for the wire driver |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Access layer takes the received byte |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte to send is offered |
| tx_ready | output | 1 | PHY takes the offered byte at this edge |
| perr | output | 1 | Parity error strobe |
| ferr | output | 1 | Frame (stop bit) error strobe |
| brk | output | 1 | Break detected strobe |
| col | output | 1 | Collision strobe while driving |

## Verification
The bench builds the block with GUARD_BITS set to 4 and the break length left at 12. The short guard makes both sides of the guard boundary cheap to reach after enable, after receptions and after a dropped enable. The same setting lets all 256 byte values be swept through the receiver as good frames and again with parity inverted. All 256 values are also swept through the transmitter, with the expected serial bits computed from the frame order. Stop-bit faults, breaks inside a frame, overwrite under back-pressure, back-to-back transmission and host pull-downs at chosen bit positions are driven as directed cases at this configuration.

// File: rtl/prog_phy_pkg.sv
package prog_phy_pkg;
  localparam int BYTE_W    = 8;
  localparam int FRAME_LEN = 12;
  localparam int CNT_W     = $clog2(FRAME_LEN);

  function automatic logic even_bit(input logic [BYTE_W-1:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/prog_phy_brk.sv
module prog_phy_brk #(
  parameter int BRK_BITS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic hit,
  output logic brk
);
  localparam int RW = $clog2(BRK_BITS + 1);
  logic [RW-1:0] run;

  assign hit = !din && (run == RW'(BRK_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0;
      brk <= 1'b0;
    end else begin
      brk <= hit;
      if (din)                        run <= '0;
      else if (run != RW'(BRK_BITS))  run <= run + 1'b1;
    end
  end
endmodule

// File: rtl/prog_phy_rx.sv
module prog_phy_rx
  import prog_phy_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic              listen,
  input  logic              abort,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              perr,
  output logic              ferr,
  output logic              busy,
  output logic              fin
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0]     cnt;
  logic                 prev;
  logic [FRAME_LEN-2:0] sh;
  logic [FRAME_LEN-2:0] nxt;
  logic                 start, par_bad, stop_bad;

  assign nxt      = {din, sh[FRAME_LEN-2:1]};
  assign busy     = (cnt != '0);
  assign fin      = (cnt == LAST) && !abort;
  assign start    = listen && !busy && prev && !din && !abort;
  assign par_bad  = nxt[BYTE_W] != even_bit(nxt[BYTE_W-1:0]);
  assign stop_bad = !(nxt[BYTE_W+1] && nxt[BYTE_W+2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      prev     <= 1'b1;
      sh       <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      perr     <= 1'b0;
      ferr     <= 1'b0;
    end else begin
      prev <= din;
      perr <= fin && par_bad;
      ferr <= fin && stop_bad;
      if (abort)      cnt <= '0;
      else if (start) cnt <= CNT_W'(1);
      else if (busy) begin
        sh  <= nxt;
        cnt <= fin ? '0 : cnt + 1'b1;
      end
      if (fin && !par_bad && !stop_bad) begin
        rx_data  <= nxt[BYTE_W-1:0];
        rx_valid <= 1'b1;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/prog_phy_tx.sv
module prog_phy_tx
  import prog_phy_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              abort,
  input  logic              din,
  output logic              dat_o,
  output logic              dat_oe,
  output logic              busy,
  output logic              last,
  output logic              col
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [FRAME_LEN-1:0] sh;
  logic [CNT_W-1:0]     cnt;
  logic                 act;

  assign busy   = act;
  assign last   = act && (cnt == LAST);
  assign dat_o  = act ? sh[0] : 1'b1;
  assign dat_oe = act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '1;
      cnt <= '0;
      act <= 1'b0;
      col <= 1'b0;
    end else begin
      col <= act && (din != sh[0]);
      if (abort) begin
        act <= 1'b0;
      end else if (load) begin
        act <= 1'b1;
        cnt <= '0;
        sh  <= {2'b11, even_bit(byte_in), byte_in, 1'b0};
      end else if (act) begin
        if (last) act <= 1'b0;
        else begin
          sh  <= {1'b1, sh[FRAME_LEN-1:1]};
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/prog_phy.sv
module prog_phy
  import prog_phy_pkg::*;
#(
  parameter int GUARD_BITS = 128,
  parameter int BRK_BITS   = 12
) (
  input  logic              clk,
  input  logic              link_en,
  input  logic              dat_i,
  output logic              dat_o,
  output logic              dat_oe,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              perr,
  output logic              ferr,
  output logic              brk,
  output logic              col
);
  localparam int GW = $clog2(GUARD_BITS + 1);

  logic          brk_hit, rx_busy, rx_fin, tx_busy, tx_last, tx_load;
  logic          listen, idle, guard_ok;
  logic [GW-1:0] gcnt;

  assign idle     = !rx_busy && !tx_busy;
  assign guard_ok = (gcnt == GW'(GUARD_BITS));
  assign tx_ready = !brk_hit && ((idle && guard_ok) || tx_last);
  assign tx_load  = tx_valid && tx_ready;
  assign listen   = !tx_busy && !tx_load;

  always_ff @(posedge clk or negedge link_en) begin
    if (!link_en)                 gcnt <= '0;
    else if (brk_hit || rx_fin)   gcnt <= '0;
    else if (idle) begin
      if (!dat_i)                 gcnt <= '0;
      else if (!guard_ok)         gcnt <= gcnt + 1'b1;
    end
  end

  prog_phy_brk #(.BRK_BITS(BRK_BITS)) u_brk (
    .clk(clk), .rst_n(link_en), .din(dat_i), .hit(brk_hit), .brk(brk)
  );

  prog_phy_rx u_rx (
    .clk(clk), .rst_n(link_en), .din(dat_i), .listen(listen), .abort(brk_hit),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .perr(perr), .ferr(ferr), .busy(rx_busy), .fin(rx_fin)
  );

  prog_phy_tx u_tx (
    .clk(clk), .rst_n(link_en), .load(tx_load), .byte_in(tx_data),
    .abort(brk_hit), .din(dat_i), .dat_o(dat_o), .dat_oe(dat_oe),
    .busy(tx_busy), .last(tx_last), .col(col)
  );
endmodule

// File: rtl/prog_phy_chk.sv
module prog_phy_chk (
  input logic clk,
  input logic link_en,
  input logic dat_o,
  input logic dat_oe,
  input logic rx_valid,
  input logic rx_ready,
  input logic tx_ready,
  input logic rx_busy,
  input logic tx_busy,
  input logic guard_ok,
  input logic perr,
  input logic ferr,
  input logic brk,
  input logic col
);
  assert_half_duplex_R11: assert property (@(posedge clk) disable iff (!link_en)
    !(rx_busy && tx_busy));

  assert_guard_before_send_R7: assert property (@(posedge clk) disable iff (!link_en)
    (tx_ready && !tx_busy) |-> (guard_ok && !rx_busy));

  assert_drive_opens_low_R8: assert property (@(posedge clk) disable iff (!link_en)
    $rose(dat_oe) |-> !dat_o);

  assert_rx_hold_R2: assert property (@(posedge clk) disable iff (!link_en)
    (rx_valid && !rx_ready) |=> rx_valid);

  assert_col_while_driving_R10: assert property (@(posedge clk) disable iff (!link_en)
    col |-> $past(dat_oe));

  assert_brk_releases_R5: assert property (@(posedge clk) disable iff (!link_en)
    brk |-> (!dat_oe && !rx_busy));

  assert_err_at_frame_end_R4: assert property (@(posedge clk) disable iff (!link_en)
    (perr || ferr) |-> $past(rx_busy));

  assert_disabled_quiet_R12: assert property (@(posedge clk)
    !link_en |-> (!dat_oe && !rx_valid && !tx_ready && !perr && !ferr && !brk && !col));
endmodule

bind prog_phy prog_phy_chk u_chk (
  .clk(clk), .link_en(link_en), .dat_o(dat_o), .dat_oe(dat_oe),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_ready(tx_ready),
  .rx_busy(rx_busy), .tx_busy(tx_busy), .guard_ok(guard_ok),
  .perr(perr), .ferr(ferr), .brk(brk), .col(col)
);

// File: tb/tb_prog_phy.sv
module tb_prog_phy;
  localparam int G = 4;

  logic       clk = 1'b0;
  logic       link_en, host_lvl, host_pull, rx_ready, tx_valid;
  logic [7:0] tx_data, rx_data;
  logic       dat_i, dat_o, dat_oe, rx_valid, tx_ready, perr, ferr, brk, col;
  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  assign dat_i = dat_oe ? (dat_o & ~host_pull) : host_lvl;

  prog_phy #(.GUARD_BITS(G), .BRK_BITS(12)) dut (
    .clk(clk), .link_en(link_en), .dat_i(dat_i), .dat_o(dat_o), .dat_oe(dat_oe),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .perr(perr), .ferr(ferr), .brk(brk), .col(col)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] frame_of(input logic [7:0] d);
    return {2'b11, ^d, d, 1'b0};
  endfunction

  task automatic send_frame(input logic [7:0] d, input logic pflip,
                            input logic s1, input logic s2);
    host_lvl = 1'b1; @(negedge clk);
    host_lvl = 1'b0; @(negedge clk);
    for (int i = 0; i < 8; i++) begin host_lvl = d[i]; @(negedge clk); end
    host_lvl = (^d) ^ pflip; @(negedge clk);
    host_lvl = s1; @(negedge clk);
    host_lvl = s2; @(negedge clk);
    host_lvl = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] d, input int pull_at,
                           output logic [11:0] bits, output int oe_n, output int col_n);
    tx_data = d; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    tx_valid = 1'b0;
    bits = '0; oe_n = 0; col_n = 0;
    for (int j = 0; j < 12; j++) begin
      host_pull = (j == pull_at);
      bits[j] = dat_o;
      if (dat_oe) oe_n++;
      if (col) col_n++;
      @(negedge clk);
    end
    host_pull = 1'b0;
    if (col) col_n++;
  endtask

  task automatic guard_check(input string req);
    repeat (G - 1) @(negedge clk);
    chk({req, " ready one short of guard"}, tx_ready, 0);
    @(negedge clk);
    chk({req, " ready at guard"}, tx_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [11:0] bits;
    int oe_n, col_n, bad, seen;
    link_en = 1'b1; host_lvl = 1'b1; host_pull = 1'b0;
    rx_ready = 1'b1; tx_valid = 1'b0; tx_data = '0;
    #1 link_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 reset oe", dat_oe, 0);
    chk("R12 reset dat_o", dat_o, 1);
    chk("R12 reset flags", {rx_valid, tx_ready, perr, ferr, brk, col}, 0);
    link_en = 1'b1;
    guard_check("R7 after enable");

    // R1 all bytes received
    bad = 0;
    for (int d = 0; d < 256; d++) begin
      send_frame(8'(d), 1'b0, 1'b1, 1'b1);
      if (!rx_valid || rx_data != 8'(d) || perr || ferr) bad++;
    end
    chk("R1 good frames mismatching", bad, 0);
    guard_check("R7 after rx frame");

    // R3 parity sweep
    bad = 0;
    for (int d = 0; d < 256; d++) begin
      send_frame(8'(d), 1'b1, 1'b1, 1'b1);
      if (rx_valid || !perr || ferr) bad++;
    end
    chk("R3 parity flips missed", bad, 0);
    @(negedge clk);
    chk("R3 perr single cycle", perr, 0);

    // R4 stop faults
    send_frame(8'h5A, 1'b0, 1'b0, 1'b1);
    chk("R4 stop1 low ferr", ferr, 1);
    chk("R4 stop1 low no byte", rx_valid, 0);
    chk("R4 stop1 low perr", perr, 0);
    send_frame(8'hA5, 1'b0, 1'b1, 1'b0);
    chk("R4 stop2 low ferr", ferr, 1);
    send_frame(8'h33, 1'b1, 1'b0, 1'b0);
    chk("R4 both faults", {perr, ferr}, 3);

    // R2 back-pressure and overwrite
    rx_ready = 1'b0;
    send_frame(8'h11, 1'b0, 1'b1, 1'b1);
    chk("R2 first byte", rx_data, 8'h11);
    send_frame(8'h22, 1'b0, 1'b1, 1'b1);
    repeat (5) @(negedge clk);
    chk("R2 held valid", rx_valid, 1);
    chk("R2 overwritten byte", rx_data, 8'h22);
    rx_ready = 1'b1; @(negedge clk);
    chk("R2 cleared on ready", rx_valid, 0);

    // R5 break from idle, R6 no start without a falling edge
    host_lvl = 1'b1; @(negedge clk);
    for (int k = 1; k <= 12; k++) begin
      host_lvl = 1'b0; @(negedge clk);
      if (k == 11) chk("R5 no break at 11 lows", brk, 0);
    end
    chk("R5 break strobe", brk, 1);
    chk("R5 aborted frame silent", {ferr, perr, rx_valid}, 0);
    seen = 0;
    repeat (6) begin @(negedge clk); seen += int'(brk) + int'(ferr) + int'(rx_valid); end
    chk("R6 held low gives nothing", seen, 0);
    chk("R7 break blocks send", tx_ready, 0);
    send_frame(8'h3C, 1'b0, 1'b1, 1'b1);
    chk("R6 frame after release", rx_data, 8'h3C);
    chk("R6 frame after release valid", rx_valid, 1);
    repeat (G + 1) @(negedge clk);

    // R8 all bytes sent, R10 quiet, R11 no echo
    bad = 0; seen = 0;
    for (int d = 0; d < 256; d++) begin
      send_byte(8'(d), -1, bits, oe_n, col_n);
      if (bits != frame_of(8'(d)) || oe_n != 12 || dat_oe) bad++;
      seen += col_n + int'(rx_valid);
    end
    chk("R8 sent frames mismatching", bad, 0);
    chk("R11 echo or R10 spurious col", seen, 0);

    // R9 back-to-back
    tx_data = 8'hC3; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    tx_data = 8'h96;
    bad = 0;
    for (int j = 0; j < 24; j++) begin
      if (j == 11) chk("R9 ready on last stop", tx_ready, 1);
      if (j == 12) tx_valid = 1'b0;
      if (!dat_oe || dat_o != (j < 12 ? frame_of(8'hC3)[j] : frame_of(8'h96)[j-12])) bad++;
      @(negedge clk);
    end
    chk("R9 joined frames", bad, 0);
    chk("R9 released after second", dat_oe, 0);

    // R10 collisions
    send_byte(8'hFF, 11, bits, oe_n, col_n);
    chk("R10 pull on high stop", col_n, 1);
    send_byte(8'hFF, 0, bits, oe_n, col_n);
    chk("R10 pull on low start", col_n, 0);
    send_byte(8'h00, 9, bits, oe_n, col_n);
    chk("R10 pull on low parity", col_n, 0);
    send_byte(8'h80, 8, bits, oe_n, col_n);
    chk("R10 pull on high msb", col_n, 1);

    // R12 enable drop mid-send and with a held byte
    rx_ready = 1'b0;
    send_frame(8'h77, 1'b0, 1'b1, 1'b1);
    repeat (G) @(negedge clk);
    tx_data = 8'hFF; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    tx_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk("R12 driving before drop", dat_oe, 1);
    link_en = 1'b0; #1;
    chk("R12 oe off at once", dat_oe, 0);
    chk("R12 state cleared", {rx_valid, tx_ready, dat_o}, 1);
    @(negedge clk);
    rx_ready = 1'b1;
    link_en = 1'b1;
    guard_check("R7 after re-enable");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule